// File: doc/BRIEF.md
# Table Pointer and Latch Unit

This block holds the byte pointer and the one-byte data latch that a small processor core uses to move bytes between its program store and its data side. The pointer is 22 bits wide and is assembled from three byte registers (low, high and upper). The upper byte keeps only the bits the pointer actually has. Bit 21 chooses between the program array (bit clear, 21 address bits) and the identification and configuration space (bit set).

Table commands arrive on a valid/ready stream. Each command is either a read or a write, and carries one of four pointer-update modes. A read presents the full pointer, or the pre-incremented pointer, to a byte-wide synchronous memory and loads the returned byte into the latch. A write copies the latch into one of eight holding bytes, selected by the low three pointer bits. The block also drives two block addresses continuously: one for an eight-byte programming row and one for a 64-byte erase block. Software loads the pointer bytes and the latch directly whenever the command path is idle.

Back-pressure: `cmd_ready` is low from the cycle after a read is accepted until the latch has been loaded. A source may hold `cmd_valid` and its payload until `cmd_ready` is high, and a command is taken on the edge where both are high. A table write never lowers `cmd_ready`. The direct pointer and latch loads have no handshake. They are dropped when they cannot be taken.

Top module: `tbl_access_unit`

## Requirements
- R1: After reset the pointer and the latch are zero, `busy`, `mem_rd_en` and `hold_we` are low, and `cmd_ready` is high.
- R2: A direct load writes one pointer byte (`ptr_wr_sel` 0 = bits 7:0, 1 = bits 15:8, 2 = the upper byte, 3 = no register). The upper byte stores only its bits 5:0 as pointer bits 21:16, and its bits 7:6 are discarded.
- R3: `cmd_mode` selects the pointer update: 0 leaves the pointer unchanged, 1 increments it after the access, 2 decrements it after the access, and 3 increments it before the access. This applies to reads (`cmd_op` = 0) and writes (`cmd_op` = 1).
- R4: An increment or decrement changes only bits 20:0 and wraps within them. Bit 21 is never altered by a command.
- R5: One cycle after a read is accepted, `mem_rd_en` is high for exactly one cycle. In that cycle `mem_rd_addr` holds all 22 bits of the incremented pointer for mode 3, or of the unchanged pointer for the other modes.
- R6: The latch loads `mem_rd_data` at the end of the cycle after `mem_rd_en`. `busy` is high for both of these cycles. A post-modify update of a read takes effect on the same edge as the latch load.
- R7: While `busy` is high, `cmd_ready` is low, and commands, pointer loads and latch loads are ignored.
- R8: One cycle after a write is accepted, `hold_we` pulses for one cycle. `hold_data` is the latch value, and `hold_idx` is bits 2:0 of the address used (the new pointer for mode 3, the old pointer otherwise). The pointer update of a write takes effect on the accepting edge.
- R9: `lw_block` always equals pointer bits 21:3.
- R10: `erase_block` always equals pointer bits 21:6.
- R11: If a command is accepted on the same edge as a direct pointer or latch load, the load is dropped.
- R12: A direct latch load (`lat_wr_en`) in an idle cycle with no accepted command replaces the latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 1 | 0 = table read, 1 = table write |
| cmd_mode | input | 2 | Pointer update mode |
| ptr_wr_en | input | 1 | Direct pointer byte load |
| ptr_wr_sel | input | 2 | Pointer byte select |
| ptr_wr_data | input | 8 | Pointer byte value |
| lat_wr_en | input | 1 | Direct latch load |
| lat_wr_data | input | 8 | Latch load value |
| ptr_q | output | 22 | Current pointer |
| lat_q | output | 8 | Current latch |
| busy | output | 1 | Read in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 22 | Memory read byte address |
| mem_rd_data | input | 8 | Memory byte, valid the cycle after the strobe |
| hold_we | output | 1 | Holding byte write strobe |
| hold_idx | output | 3 | Holding byte index |
| hold_data | output | 8 | Holding byte value |
| lw_block | output | 19 | Eight-byte programming row address |
| erase_block | output | 16 | 64-byte erase block address |

## Verification
The assertions check on every cycle that the read strobe lasts a single cycle inside a busy window, that a read never presents a space bit different from the pointer's, that bit 21 changes only through a direct upper-byte load, and that a holding write is always the echo of an accepted write command and never overlaps a read. Only the bench scenarios can show the arithmetic: the pointer value after each mode at the 21-bit wrap points, which byte reaches the latch, the holding index picked by pre- and post-modify, the two block-address slices, and the dropping of loads while busy or on a command edge.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  localparam logic       OP_READ  = 1'b0;
  localparam logic       OP_WRITE = 1'b1;

  localparam logic [1:0] MODE_KEEP     = 2'd0;
  localparam logic [1:0] MODE_POST_INC = 2'd1;
  localparam logic [1:0] MODE_POST_DEC = 2'd2;
  localparam logic [1:0] MODE_PRE_INC  = 2'd3;

  localparam logic [1:0] SEL_LOW   = 2'd0;
  localparam logic [1:0] SEL_HIGH  = 2'd1;
  localparam logic [1:0] SEL_UPPER = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_ADDR = 2'd1,
    ST_RD_DATA = 2'd2
  } seq_state_t;
endpackage

// File: rtl/tbl_ptr_file.sv
module tbl_ptr_file #(
  parameter int PTR_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [1:0]       sw_sel,
  input  logic [7:0]       sw_data,
  input  logic             step_en,
  input  logic             step_down,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptr_inc
);
  localparam int LO_W  = PTR_W - 1;
  localparam int LANES = (PTR_W + 7) / 8;

  logic [LO_W-1:0]  lo_up, lo_dn;
  logic [PTR_W-1:0] ptr_step;

  // arithmetic stays inside the low field; the space bit is carried over
  assign lo_up    = ptr[LO_W-1:0] + LO_W'(1);
  assign lo_dn    = ptr[LO_W-1:0] - LO_W'(1);
  assign ptr_inc  = {ptr[PTR_W-1], lo_up};
  assign ptr_step = step_down ? {ptr[PTR_W-1], lo_dn} : ptr_inc;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam int LW = ((PTR_W - 8*b) > 8) ? 8 : (PTR_W - 8*b);
    logic [LW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        lane_q <= '0;
      else if (step_en)
        lane_q <= ptr_step[8*b +: LW];
      else if (sw_we && (sw_sel == 2'(b)))
        lane_q <= sw_data[LW-1:0];
    end
    assign ptr[8*b +: LW] = lane_q;
  end
endmodule

// File: rtl/tbl_blk_addr.sv
module tbl_blk_addr #(
  parameter int PTR_W   = 22,
  parameter int ROW_SH  = 3,
  parameter int ERASE_SH = 6
) (
  input  logic [PTR_W-1:0]          ptr,
  output logic [PTR_W-ROW_SH-1:0]   row_addr,
  output logic [PTR_W-ERASE_SH-1:0] erase_addr
);
  // the low offset bits are dropped, not used
  assign row_addr   = ptr[PTR_W-1:ROW_SH];
  assign erase_addr = ptr[PTR_W-1:ERASE_SH];
endmodule

// File: rtl/tbl_seq.sv
module tbl_seq
  import tbl_pkg::*;
#(
  parameter int PTR_W      = 22,
  parameter int DATA_W     = 8,
  parameter int HOLD_IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic                  cmd_op,
  input  logic [1:0]            cmd_mode,
  output logic                  cmd_ready,
  output logic                  busy,
  input  logic [PTR_W-1:0]      ptr,
  input  logic [PTR_W-1:0]      ptr_inc,
  output logic                  step_en,
  output logic                  step_down,
  output logic                  sw_allow,
  input  logic                  lat_wr_en,
  input  logic [DATA_W-1:0]     lat_wr_data,
  output logic [DATA_W-1:0]     lat_q,
  output logic                  mem_rd_en,
  output logic [PTR_W-1:0]      mem_rd_addr,
  input  logic [DATA_W-1:0]     mem_rd_data,
  output logic                  hold_we,
  output logic [HOLD_IDX_W-1:0] hold_idx,
  output logic [DATA_W-1:0]     hold_data
);
  seq_state_t       st_q;
  logic [1:0]       mode_q;
  logic [PTR_W-1:0] addr_q;
  logic             accept;
  logic [PTR_W-1:0] use_addr;

  assign cmd_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign sw_allow  = cmd_ready && !accept;
  assign use_addr  = (cmd_mode == MODE_PRE_INC) ? ptr_inc : ptr;
  assign mem_rd_en   = (st_q == ST_RD_ADDR);
  assign mem_rd_addr = addr_q;

  always_comb begin
    step_en   = 1'b0;
    step_down = 1'b0;
    if (accept) begin
      if (cmd_mode == MODE_PRE_INC) begin
        step_en = 1'b1;
      end else if (cmd_op == OP_WRITE && cmd_mode == MODE_POST_INC) begin
        step_en = 1'b1;
      end else if (cmd_op == OP_WRITE && cmd_mode == MODE_POST_DEC) begin
        step_en   = 1'b1;
        step_down = 1'b1;
      end
    end else if (st_q == ST_RD_DATA) begin
      if (mode_q == MODE_POST_INC) begin
        step_en = 1'b1;
      end else if (mode_q == MODE_POST_DEC) begin
        step_en   = 1'b1;
        step_down = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mode_q    <= MODE_KEEP;
      addr_q    <= '0;
      lat_q     <= '0;
      hold_we   <= 1'b0;
      hold_idx  <= '0;
      hold_data <= '0;
    end else begin
      hold_we <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept && cmd_op == OP_READ) begin
            st_q   <= ST_RD_ADDR;
            mode_q <= cmd_mode;
            addr_q <= use_addr;
          end else if (accept) begin
            hold_we   <= 1'b1;
            hold_idx  <= use_addr[HOLD_IDX_W-1:0];
            hold_data <= lat_q;
          end else if (lat_wr_en) begin
            lat_q <= lat_wr_data;
          end
        end
        ST_RD_ADDR: st_q <= ST_RD_DATA;
        ST_RD_DATA: begin
          lat_q <= mem_rd_data;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tbl_access_unit.sv
module tbl_access_unit #(
  parameter int PTR_W       = 22,
  parameter int DATA_W      = 8,
  parameter int HOLD_BYTES  = 8,
  parameter int ERASE_BYTES = 64,
  parameter int HOLD_IDX_W  = $clog2(HOLD_BYTES),
  parameter int ERASE_SH    = $clog2(ERASE_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic                        cmd_op,
  input  logic [1:0]                  cmd_mode,
  input  logic                        ptr_wr_en,
  input  logic [1:0]                  ptr_wr_sel,
  input  logic [7:0]                  ptr_wr_data,
  input  logic                        lat_wr_en,
  input  logic [DATA_W-1:0]           lat_wr_data,
  output logic [PTR_W-1:0]            ptr_q,
  output logic [DATA_W-1:0]           lat_q,
  output logic                        busy,
  output logic                        mem_rd_en,
  output logic [PTR_W-1:0]            mem_rd_addr,
  input  logic [DATA_W-1:0]           mem_rd_data,
  output logic                        hold_we,
  output logic [HOLD_IDX_W-1:0]       hold_idx,
  output logic [DATA_W-1:0]           hold_data,
  output logic [PTR_W-HOLD_IDX_W-1:0] lw_block,
  output logic [PTR_W-ERASE_SH-1:0]   erase_block
);
  logic [PTR_W-1:0] ptr_inc;
  logic             step_en, step_down, sw_allow;

  tbl_ptr_file #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .sw_we(ptr_wr_en && sw_allow), .sw_sel(ptr_wr_sel), .sw_data(ptr_wr_data),
    .step_en(step_en), .step_down(step_down),
    .ptr(ptr_q), .ptr_inc(ptr_inc)
  );

  tbl_seq #(.PTR_W(PTR_W), .DATA_W(DATA_W), .HOLD_IDX_W(HOLD_IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mode(cmd_mode),
    .cmd_ready(cmd_ready), .busy(busy),
    .ptr(ptr_q), .ptr_inc(ptr_inc),
    .step_en(step_en), .step_down(step_down), .sw_allow(sw_allow),
    .lat_wr_en(lat_wr_en), .lat_wr_data(lat_wr_data), .lat_q(lat_q),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .hold_we(hold_we), .hold_idx(hold_idx), .hold_data(hold_data)
  );

  tbl_blk_addr #(.PTR_W(PTR_W), .ROW_SH(HOLD_IDX_W), .ERASE_SH(ERASE_SH)) u_blk (
    .ptr(ptr_q), .row_addr(lw_block), .erase_addr(erase_block)
  );
endmodule

// File: rtl/tbl_access_unit_chk.sv
module tbl_access_unit_chk #(
  parameter int PTR_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_op,
  input logic             ptr_wr_en,
  input logic [1:0]       ptr_wr_sel,
  input logic [PTR_W-1:0] ptr_q,
  input logic             busy,
  input logic             mem_rd_en,
  input logic [PTR_W-1:0] mem_rd_addr,
  input logic             hold_we
);
  assert_rd_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en && busy);

  assert_rd_inside_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

  assert_rd_space_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_rd_addr[PTR_W-1] == ptr_q[PTR_W-1]);

  assert_space_bit_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ptr_wr_en && ptr_wr_sel == 2'd2) |-> ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1]));

  assert_hold_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_we |-> $past(cmd_valid && cmd_ready && cmd_op));

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_we && mem_rd_en));
endmodule

bind tbl_access_unit tbl_access_unit_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
  .ptr_q(ptr_q), .busy(busy), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .hold_we(hold_we)
);

// File: tb/sim_tbl_access_unit.sv
`timescale 1ns/1ps
module sim_tbl_access_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [1:0]  cmd_mode = 2'd0;
  logic        ptr_wr_en = 1'b0;
  logic [1:0]  ptr_wr_sel = 2'd3;
  logic [7:0]  ptr_wr_data = 8'd0;
  logic        lat_wr_en = 1'b0;
  logic [7:0]  lat_wr_data = 8'd0;
  logic        cmd_ready, busy, mem_rd_en, hold_we;
  logic [21:0] ptr_q, mem_rd_addr;
  logic [7:0]  lat_q, hold_data;
  logic [7:0]  mem_q = 8'd0;
  logic [2:0]  hold_idx;
  logic [18:0] lw_block;
  logic [15:0] erase_block;

  int checks = 0, fails = 0, hold_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tbl_access_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mode(cmd_mode), .ptr_wr_en(ptr_wr_en),
    .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data), .lat_wr_en(lat_wr_en),
    .lat_wr_data(lat_wr_data), .ptr_q(ptr_q), .lat_q(lat_q), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_q),
    .hold_we(hold_we), .hold_idx(hold_idx), .hold_data(hold_data),
    .lw_block(lw_block), .erase_block(erase_block)
  );

  function automatic logic [7:0] fmem(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'hC3;
  endfunction

  function automatic logic [21:0] stepped(input logic [21:0] p, input bit down);
    logic [20:0] lo;
    lo = down ? p[20:0] - 21'd1 : p[20:0] + 21'd1;
    return {p[21], lo};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_q <= fmem(mem_rd_addr);
  always @(negedge clk) if (hold_we) hold_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_byte(input logic [1:0] sel, input logic [7:0] d);
    ptr_wr_en = 1'b1; ptr_wr_sel = sel; ptr_wr_data = d;
    @(negedge clk);
    ptr_wr_en = 1'b0; ptr_wr_sel = 2'd3;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    load_byte(2'd0, p[7:0]);
    load_byte(2'd1, p[15:8]);
    load_byte(2'd2, {2'b11, p[21:16]});   // R2: top two bits must be discarded
    chk(ptr_q == p, "R2 pointer load", 32'(ptr_q), 32'(p));
    chk(lw_block == p[21:3], "R9 row address", 32'(lw_block), 32'(p[21:3]));
    chk(erase_block == p[21:6], "R10 erase address", 32'(erase_block), 32'(p[21:6]));
  endtask

  task automatic set_lat(input logic [7:0] d);
    lat_wr_en = 1'b1; lat_wr_data = d;
    @(negedge clk);
    lat_wr_en = 1'b0;
    chk(lat_q == d, "R12 latch load", 32'(lat_q), 32'(d));
  endtask

  function automatic logic [21:0] final_ptr(input logic [21:0] p, input logic [1:0] m);
    case (m)
      2'd0: return p;
      2'd2: return stepped(p, 1'b1);
      default: return stepped(p, 1'b0);
    endcase
  endfunction

  task automatic run_read(input logic [21:0] p, input logic [1:0] m);
    logic [21:0] ea, ef;
    ea = (m == 2'd3) ? stepped(p, 1'b0) : p;
    ef = final_ptr(p, m);
    set_ptr(p);
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_mode = m;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(mem_rd_en == 1'b1, "R5 read strobe", 32'(mem_rd_en), 32'd1);
    chk(mem_rd_addr == ea, "R5 read address", 32'(mem_rd_addr), 32'(ea));
    chk(busy && !cmd_ready, "R7 busy/ready", 32'({busy, cmd_ready}), 32'h2);
    @(negedge clk);
    chk(busy && !mem_rd_en, "R6 data cycle", 32'({busy, mem_rd_en}), 32'h2);
    chk(ptr_q == ((m == 2'd3) ? ea : p), "R6 post update deferred", 32'(ptr_q), 32'((m == 2'd3) ? ea : p));
    @(negedge clk);
    chk(lat_q == fmem(ea), "R6 latch from memory", 32'(lat_q), 32'(fmem(ea)));
    chk(ptr_q == ef, "R3 R4 read pointer update", 32'(ptr_q), 32'(ef));
    chk(!busy && cmd_ready, "R6 busy clears", 32'({busy, cmd_ready}), 32'h1);
  endtask

  task automatic run_write(input logic [21:0] p, input logic [1:0] m, input logic [7:0] d);
    logic [21:0] ea, ef;
    ea = (m == 2'd3) ? stepped(p, 1'b0) : p;
    ef = final_ptr(p, m);
    set_ptr(p);
    set_lat(d);
    cmd_valid = 1'b1; cmd_op = 1'b1; cmd_mode = m;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(hold_we == 1'b1, "R8 hold strobe", 32'(hold_we), 32'd1);
    chk(hold_idx == ea[2:0], "R8 hold index", 32'(hold_idx), 32'(ea[2:0]));
    chk(hold_data == d, "R8 hold data", 32'(hold_data), 32'(d));
    chk(ptr_q == ef, "R3 R4 write pointer update", 32'(ptr_q), 32'(ef));
    chk(cmd_ready == 1'b1, "R8 no stall", 32'(cmd_ready), 32'd1);
    @(negedge clk);
    chk(hold_we == 1'b0, "R8 single pulse", 32'(hold_we), 32'd0);
  endtask

  initial begin
    logic [21:0] pv [6];
    pv[0] = 22'h000000; pv[1] = 22'h1FFFFF; pv[2] = 22'h200000;
    pv[3] = 22'h3FFFFF; pv[4] = 22'h0ABC47; pv[5] = 22'h23FFC0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ptr_q == 22'd0 && lat_q == 8'd0, "R1 reset regs", 32'({ptr_q, lat_q}), 32'd0);
    chk(!busy && !mem_rd_en && !hold_we && cmd_ready, "R1 reset flags",
        32'({busy, mem_rd_en, hold_we, cmd_ready}), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 upper byte keeps six bits
    load_byte(2'd2, 8'hFF);
    chk(ptr_q[21:16] == 6'h3F, "R2 upper byte", 32'(ptr_q[21:16]), 32'h3F);
    load_byte(2'd3, 8'h55);
    chk(ptr_q == 22'h3F0000, "R2 select 3 ignored", 32'(ptr_q), 32'h3F0000);

    // sweep of pointers, modes and operations (R3 R4 R5 R6 R8 R9 R10 R12)
    for (int v = 0; v < 6; v++) begin
      for (int m = 0; m < 4; m++) begin
        run_read(pv[v], 2'(m));
        run_write(pv[v], 2'(m), 8'(8'h30 + 8'(v * 4 + m)));
      end
    end

    // R7 loads and commands ignored while busy
    begin
      int hc;
      set_ptr(22'h012345);
      set_lat(8'h9E);
      cmd_valid = 1'b1; cmd_op = 1'b0; cmd_mode = 2'd0;
      @(negedge clk);
      hc = hold_cnt;
      cmd_op = 1'b1;                      // held valid, now a write
      ptr_wr_en = 1'b1; ptr_wr_sel = 2'd0; ptr_wr_data = 8'hAA;
      lat_wr_en = 1'b1; lat_wr_data = 8'h77;
      chk(cmd_ready == 1'b0, "R7 ready low", 32'(cmd_ready), 32'd0);
      @(negedge clk);
      cmd_valid = 1'b0; ptr_wr_en = 1'b0; lat_wr_en = 1'b0;
      @(negedge clk);
      chk(ptr_q == 22'h012345, "R7 pointer kept", 32'(ptr_q), 32'h012345);
      chk(lat_q == fmem(22'h012345), "R7 latch from read", 32'(lat_q), 32'(fmem(22'h012345)));
      chk(hold_cnt == hc, "R7 command ignored", 32'(hold_cnt), 32'(hc));
    end

    // R11 command beats direct loads on the same edge
    set_ptr(22'h1A2B3C);
    set_lat(8'h5D);
    cmd_valid = 1'b1; cmd_op = 1'b1; cmd_mode = 2'd0;
    ptr_wr_en = 1'b1; ptr_wr_sel = 2'd0; ptr_wr_data = 8'h11;
    lat_wr_en = 1'b1; lat_wr_data = 8'h22;
    @(negedge clk);
    cmd_valid = 1'b0; ptr_wr_en = 1'b0; lat_wr_en = 1'b0;
    chk(ptr_q == 22'h1A2B3C, "R11 pointer load dropped", 32'(ptr_q), 32'h1A2B3C);
    chk(lat_q == 8'h5D, "R11 latch load dropped", 32'(lat_q), 32'h5D);
    chk(hold_we && hold_data == 8'h5D, "R11 write used old latch", 32'(hold_data), 32'h5D);
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule